// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds the time of day and the calendar date as packed BCD bytes and advances them from a strobe input. It keeps seven fields: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A carry ripples through them, so a single second can roll every field at once. The hours byte runs in either a 12-hour or a 24-hour format, chosen by a flag bit inside that byte.

The strobe `tick_i` arrives `TICKS_PER_SEC` times per second. An internal sub-second counter turns it into one step of the seconds field. With `TICKS_PER_SEC = 1` the strobe is a plain one-pulse-per-second input. Month lengths and leap years are handled in hardware, so the date always rolls to the first of the next month at the right time. A freeze input stops all counting. A byte-wide write port sets any field, and all seven fields are driven out in parallel for other logic to read.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, the fields read seconds 00, minutes 00, hours 00 in 24-hour format, weekday 01, date 01, month 01 and year 00.
- R2: Every field counts in packed BCD. The units nibble steps 0 to 9, and on the step after 9 it returns to 0 while the tens nibble goes up by one.
- R3: Seconds advance by one after every `TICKS_PER_SEC` strobes. Seconds wrap from 59 to 00 and step the minutes, and minutes wrap from 59 to 00 and step the hours.
- R4: When bit 6 of the hours byte is 0 (24-hour format), hours run 00 to 23. The step after 23 gives 00 and advances the day. Bit 5 is the tens bit here, not a PM flag.
- R5: When bit 6 of the hours byte is 1 (12-hour format), bit 5 is PM (1 = PM) and bits 4:0 hold 01 to 12. The sequence is 11 to 12 with the PM flag toggled, then 12 to 01 with the flag kept. The day advances only on the step from 11 PM to 12 AM.
- R6: On a day advance the date wraps to 01 and the month steps after the last day of the month. The last day is 31 for months 01, 03, 05, 07, 08, 10 and 12, 30 for months 04, 06, 09 and 11, and 28 or 29 for month 02.
- R7: February has 29 days when the year value (00 to 99) is divisible by 4, including 00, and 28 days otherwise.
- R8: Month 12 wraps to 01 and steps the year, and year 99 wraps to 00.
- R9: The weekday counts 1 to 7 on each day advance, and 7 wraps to 1.
- R10: While `halt_i` is 1, strobes are ignored and neither the fields nor the sub-second count change. Writes still take effect.
- R11: Write addresses are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year. Address 7 changes nothing.
  - A write overrides counting of that field in the same cycle.
  - Bits beyond each field are stored as 0: bit 7 of seconds, minutes and hours, bits 7:3 of weekday, bits 7:6 of date, and bits 7:5 of month.
- R12: Writing the seconds field clears the sub-second count. The next seconds step comes a full `TICKS_PER_SEC` strobes after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sub-second strobe, one cycle per pulse |
| halt_i | input | 1 | 1 freezes counting, 0 lets it run |
| wr_en_i | input | 1 | Field write strobe |
| wr_addr_i | input | 3 | Field select for a write |
| wr_data_i | input | 8 | Write data, packed BCD |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours with format and PM flags |
| dow_o | output | 8 | Weekday 1 to 7 |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Two-digit year |

## Verification
The bench aims at the rollovers where a ripple carry or a date limit is easy to get wrong:
- The midnight of 31/12/99 rolls every field at once.
- The ends of 30-day months are covered.
- February is tested with leap and non-leap years of both tens parities, and with year 00. A wrong leap rule would give 29/02 in a common year, or 01/03 in a leap year.
- In 12-hour format, the bench checks the 11-to-12 step, which must toggle PM, and the 12-to-01 step, which must not. It also checks that only 11 PM to 12 AM advances the weekday and the date.
- A write that lands on the same cycle as a completing strobe must win, and must leave the sub-second count cleared.
- Frozen strobes must leave the phase of the next second unchanged.

// File: rtl/bcd_cal_pkg.sv
`timescale 1ns/1ps
package bcd_cal_pkg;

  localparam int unsigned N_FIELDS = 7;

  // field write addresses
  localparam logic [2:0] F_SEC   = 3'd0;
  localparam logic [2:0] F_MIN   = 3'd1;
  localparam logic [2:0] F_HOUR  = 3'd2;
  localparam logic [2:0] F_DOW   = 3'd3;
  localparam logic [2:0] F_DATE  = 3'd4;
  localparam logic [2:0] F_MONTH = 3'd5;
  localparam logic [2:0] F_YEAR  = 3'd6;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // year in BCD divisible by 4: even tens -> units 0/4/8, odd tens -> units 2/6
  function automatic logic is_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_field_cnt.sv
`timescale 1ns/1ps
module bcd_field_cnt
  import bcd_cal_pkg::*;
#(
  parameter logic [7:0] LO   = 8'h00,
  parameter logic [7:0] RST  = 8'h00,
  parameter logic [7:0] MASK = 8'h7F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic [7:0] limit_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] val_o,
  output logic       wrap_o
);

  logic [7:0] val_q;

  // >= so an out-of-range write still wraps on the next step
  assign wrap_o = step_i & ~wr_i & (val_q >= limit_i);
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= RST;
    else if (wr_i)   val_q <= wr_data_i & MASK;
    else if (wrap_o) val_q <= LO;
    else if (step_i) val_q <= bcd_inc(val_q);
  end

  p_bcd_digit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_i && val_q < limit_i && val_q[3:0] <= 4'd9) |=> (val_q[3:0] <= 4'd9));

  p_wrap_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (val_q == LO));

endmodule

// File: rtl/bcd_hour_cnt.sv
`timescale 1ns/1ps
module bcd_hour_cnt (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] hour_o,
  output logic       day_o
);

  logic [7:0] hour_q, hour_d;
  logic       day_c;
  logic       fmt12, pm;
  logic [3:0] units;

  assign fmt12 = hour_q[6];
  assign pm    = hour_q[5];
  assign units = hour_q[3:0];

  always_comb begin
    hour_d = hour_q;
    day_c  = 1'b0;
    if (fmt12) begin
      if (hour_q[4:0] >= 5'h12) begin
        hour_d = {2'b01, pm, 5'h01};
      end else if (hour_q[4:0] == 5'h11) begin
        hour_d = {2'b01, ~pm, 5'h12};
        day_c  = pm;                       // 11 PM -> 12 AM
      end else if (units == 4'd9) begin
        hour_d = {2'b01, pm, 1'b1, 4'd0};
      end else begin
        hour_d = {2'b01, pm, hour_q[4], units + 4'd1};
      end
    end else begin
      if (hour_q[5:0] >= 6'h23) begin
        hour_d = 8'h00;
        day_c  = 1'b1;
      end else if (units == 4'd9) begin
        hour_d = {2'b00, hour_q[5:4] + 2'd1, 4'd0};
      end else begin
        hour_d = {2'b00, hour_q[5:4], units + 4'd1};
      end
    end
  end

  assign day_o  = step_i & ~wr_i & day_c;
  assign hour_o = hour_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hour_q <= 8'h00;
    else if (wr_i)   hour_q <= wr_data_i & 8'h7F;
    else if (step_i) hour_q <= hour_d;
  end

  p_pm_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_i && hour_q[6] && hour_q[4:0] == 5'h11)
      |=> (hour_q[5] != $past(hour_q[5])) && (hour_q[4:0] == 5'h12));

  p_midnight_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_o |=> (hour_q == 8'h00) || (hour_q == 8'h52));

endmodule

// File: rtl/bcd_calendar.sv
`timescale 1ns/1ps
module bcd_calendar
  import bcd_cal_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       halt_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);

  localparam int unsigned SW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(TICKS_PER_SEC - 1);

  logic [N_FIELDS-1:0] wr_sel;
  logic [SW-1:0]       sub_q;
  logic                run, sec_step;
  logic                sec_wrap, min_wrap, day_adv, date_wrap, month_wrap;
  logic                dow_wrap, year_wrap;
  logic [7:0]          date_lim;

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_wsel
    assign wr_sel[i] = wr_en_i && (wr_addr_i == 3'(i));
  end

  assign run      = tick_i & ~halt_i;
  assign sec_step = run & (sub_q == SUB_LAST);
  assign date_lim = last_day(month_o, year_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             sub_q <= '0;
    else if (wr_sel[F_SEC])  sub_q <= '0;
    else if (sec_step)       sub_q <= '0;
    else if (run)            sub_q <= sub_q + SW'(1);
  end

  bcd_field_cnt #(.LO(8'h00), .RST(8'h00), .MASK(8'h7F)) u_sec (
    .clk_i, .rst_ni, .step_i(sec_step), .limit_i(8'h59), .wr_i(wr_sel[F_SEC]),
    .wr_data_i, .val_o(sec_o), .wrap_o(sec_wrap));

  bcd_field_cnt #(.LO(8'h00), .RST(8'h00), .MASK(8'h7F)) u_min (
    .clk_i, .rst_ni, .step_i(sec_wrap), .limit_i(8'h59), .wr_i(wr_sel[F_MIN]),
    .wr_data_i, .val_o(min_o), .wrap_o(min_wrap));

  bcd_hour_cnt u_hour (
    .clk_i, .rst_ni, .step_i(min_wrap), .wr_i(wr_sel[F_HOUR]),
    .wr_data_i, .hour_o, .day_o(day_adv));

  bcd_field_cnt #(.LO(8'h01), .RST(8'h01), .MASK(8'h07)) u_dow (
    .clk_i, .rst_ni, .step_i(day_adv), .limit_i(8'h07), .wr_i(wr_sel[F_DOW]),
    .wr_data_i, .val_o(dow_o), .wrap_o(dow_wrap));

  bcd_field_cnt #(.LO(8'h01), .RST(8'h01), .MASK(8'h3F)) u_date (
    .clk_i, .rst_ni, .step_i(day_adv), .limit_i(date_lim), .wr_i(wr_sel[F_DATE]),
    .wr_data_i, .val_o(date_o), .wrap_o(date_wrap));

  bcd_field_cnt #(.LO(8'h01), .RST(8'h01), .MASK(8'h1F)) u_month (
    .clk_i, .rst_ni, .step_i(date_wrap), .limit_i(8'h12), .wr_i(wr_sel[F_MONTH]),
    .wr_data_i, .val_o(month_o), .wrap_o(month_wrap));

  bcd_field_cnt #(.LO(8'h00), .RST(8'h00), .MASK(8'hFF)) u_year (
    .clk_i, .rst_ni, .step_i(month_wrap), .limit_i(8'h99), .wr_i(wr_sel[F_YEAR]),
    .wr_data_i, .val_o(year_o), .wrap_o(year_wrap));

  p_halt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !wr_en_i) |=> $stable(sec_o) && $stable(min_o) && $stable(hour_o)
                          && $stable(date_o) && $stable(month_o) && $stable(year_o));

  p_date_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_adv && !wr_en_i && date_o == date_lim) |=> (date_o == 8'h01));

  p_dow_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_adv && !wr_en_i && dow_o == 8'h07) |=> (dow_o == 8'h01));

  p_sec_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel[F_SEC] |=> (sec_o == ($past(wr_data_i) & 8'h7F)));

  p_year_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    year_wrap |=> (year_o == 8'h00));

endmodule

// File: tb/bcd_calendar_tb.sv
`timescale 1ns/1ps
module bcd_calendar_tb;

  localparam int TPS = 4;
  localparam int NV  = 20;

  // {set: sec,min,hour,dow,date,month,year , expected after one second}
  localparam logic [111:0] VEC [NV] = '{
    112'h00000003150621_01000003150621, // R3 plain step
    112'h09341203150621_10341203150621, // R2 units 9 -> tens
    112'h59590902100322_00001002100322, // R2 R3 hour 09 -> 10
    112'h59592307311299_00000001010100, // R4 R8 R9 full rollover
    112'h59592302300423_00000003010523, // R6 30-day month
    112'h59592302280223_00000003010323, // R7 common year
    112'h59592302280224_00000003290224, // R7 leap year
    112'h59592305290200_00000006010300, // R7 year 00 leap
    112'h59592301300123_00000002310123, // R6 31-day month continues
    112'h59595101300123_00007201300123, // R5 11 AM -> 12 PM
    112'h59597104150721_00005205160721, // R5 R9 11 PM -> 12 AM
    112'h59597204150721_00006104150721, // R5 12 PM -> 1 PM
    112'h59591104150721_00001204150721, // R4 24h 11 -> 12, no PM
    112'h59595204150721_00004104150721, // R5 12 AM -> 1 AM
    112'h59592306300923_00000007011023, // R6 Sep end
    112'h59592307310823_00000001010923, // R6 R9 Aug end
    112'h59592303280230_00000004010330, // R7 odd tens common
    112'h59592303280296_00000004290296, // R7 odd tens leap
    112'h59592303311023_00000004011123, // R6 Oct end
    112'h59592203311023_00002303311023  // R4 22 -> 23
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       halt_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  bcd_calendar #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk_i(clk), .rst_ni, .tick_i, .halt_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .sec_o, .min_o, .hour_o, .dow_o, .date_o, .month_o, .year_o);

  function automatic logic [7:0] fld(input int k);
    case (k)
      0: return sec_o;
      1: return min_o;
      2: return hour_o;
      3: return dow_o;
      4: return date_o;
      5: return month_o;
      default: return year_o;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] m_before;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sec",   sec_o,   8'h00);
    check("R1 min",   min_o,   8'h00);
    check("R1 hour",  hour_o,  8'h00);
    check("R1 dow",   dow_o,   8'h01);
    check("R1 date",  date_o,  8'h01);
    check("R1 month", month_o, 8'h01);
    check("R1 year",  year_o,  8'h00);
    rst_ni = 1'b1;
    @(negedge clk);

    // table walk: write all fields (seconds last), one second of strobes
    for (int v = 0; v < NV; v++) begin
      for (int k = 6; k >= 0; k--) wr(3'(k), VEC[v][111 - 8*k -: 8]);
      ticks(TPS);
      for (int k = 0; k < 7; k++)
        check($sformatf("table vector %0d field %0d", v, k), fld(k), VEC[v][55 - 8*k -: 8]);
    end

    // R12 seconds write restarts the sub-second phase
    wr(3'd0, 8'h20);
    ticks(TPS - 1);
    check("R12 no step before full second", sec_o, 8'h20);
    ticks(1);
    check("R12 step after full second", sec_o, 8'h21);
    ticks(2);
    wr(3'd0, 8'h40);
    ticks(TPS - 1);
    check("R12 partial phase discarded", sec_o, 8'h40);
    ticks(1);
    check("R12 step after rewrite", sec_o, 8'h41);

    // R10 halt freezes fields and sub-second count
    ticks(2);
    halt_i = 1'b1;
    ticks(3 * TPS);
    check("R10 sec frozen", sec_o, 8'h41);
    wr(3'd1, 8'h33);
    check("R10 write during halt", min_o, 8'h33);
    halt_i = 1'b0;
    ticks(TPS - 3);
    check("R10 phase held", sec_o, 8'h41);
    ticks(1);
    check("R10 resumes", sec_o, 8'h42);

    // R11 masking and ignored address
    wr(3'd3, 8'hFF);  check("R11 dow mask",   dow_o,   8'h07);
    wr(3'd0, 8'hD9);  check("R11 sec mask",   sec_o,   8'h59);
    wr(3'd4, 8'hF1);  check("R11 date mask",  date_o,  8'h31);
    wr(3'd5, 8'hF2);  check("R11 month mask", month_o, 8'h12);
    wr(3'd2, 8'hA3);  check("R11 hour mask",  hour_o,  8'h23);
    wr(3'd6, 8'h47);
    wr(3'd7, 8'h55);
    check("R11 addr7 sec",   sec_o,   8'h59);
    check("R11 addr7 min",   min_o,   8'h33);
    check("R11 addr7 hour",  hour_o,  8'h23);
    check("R11 addr7 dow",   dow_o,   8'h07);
    check("R11 addr7 date",  date_o,  8'h31);
    check("R11 addr7 month", month_o, 8'h12);
    check("R11 addr7 year",  year_o,  8'h47);

    // R11 write beats a completing strobe in the same cycle
    ticks(TPS - 1);
    m_before = min_o;
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 3'd0; wr_data_i = 8'h30;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    check("R11 write priority sec", sec_o, 8'h30);
    check("R11 no carry on write", min_o, m_before);
    ticks(TPS - 1);
    check("R12 cleared on collide", sec_o, 8'h30);
    ticks(1);
    check("R12 step after collide", sec_o, 8'h31);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule